// File: doc/BRIEF.md
# Dynamically Sized Bus Read Controller

This block is a bus master that carries out read cycles on an asynchronous, handshaked external bus. A request gives a byte address, a 3-bit function code and an operand size of one, two, three or four bytes. The controller runs one or more bus cycles and returns the assembled operand together with a single-cycle completion pulse.

In each bus cycle the controller drives the address, the function code and the count of bytes still outstanding. It then asserts the strobes and waits for a two-line, active-low acknowledge. The acknowledge also reports the width of the responding port: 32, 16 or 8 bits. From that width and the low address bits, the controller works out how many bytes the cycle delivered and which data lanes carried them. It writes those bytes into the operand register. It then advances the address and, if bytes remain, starts another cycle. A new cycle is held off until the acknowledge lines have been seen negated.

Top module: `dynsz_rd_ctrl`

## Requirements
- R1: A request is taken only in a clock where `busy` is 0, `req_valid` is 1 and `xfer_ack_n` is 2'b11. `busy` is 1 from the following clock. A `req_valid` raised while `busy` is 1 has no effect on the transfer or on the result.
- R2: During every bus cycle, `bus_size` gives the remaining byte count, encoded 2'b00 = four, 2'b01 = one, 2'b10 = two and 2'b11 = three. `bus_func` carries the request's function code. `bus_size` stays stable while `adr_stb_n` is low.
- R3: Each bus cycle begins with `cyc_early_n` low for exactly one clock, which is the clock before `adr_stb_n` and `dat_stb_n` fall. `bus_read` is 1 throughout.
- R4: `dbuf_oe_n` falls one clock after the strobes fall and rises one clock after the strobes rise.
- R5: The strobes stay low while `xfer_ack_n` is 2'b11. In the clock after the acknowledge is sampled with the buffer enabled, both strobes are high.
- R6: `xfer_ack_n` encodes the port width: 2'b00 is 32-bit, 2'b01 is 16-bit and 2'b10 is 8-bit. Each cycle moves min(remaining, width_bytes - offset) bytes. The offset is `bus_addr[1:0]` on a 32-bit port, `bus_addr[0]` on a 16-bit port and 0 on an 8-bit port.
- R7: The byte at port offset o is taken from `bus_din[31-8*o -: 8]`. A 16-bit port therefore uses D31–D16 and an 8-bit port uses D31–D24. All other lanes are ignored.
- R8: `rd_data` holds the operand right-justified, with the lowest-addressed byte most significant. Bits above the operand size are 0.
- R9: After each cycle, the address advances by the number of bytes moved, wrapping modulo 2^ADDR_W, and the remaining count drops by the same amount.
- R10: While `xfer_ack_n` is not 2'b11, no new cycle starts (`cyc_early_n` stays high) and `done` is not raised.
- R11: `done` is a one-clock pulse. It is raised once the remaining count is zero and the acknowledge has been released. `rd_data` is valid in that clock and `busy` is 0.
- R12: While reset is asserted, all strobes and enables are high, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_fc | input | 3 | Function code for the request |
| req_size | input | 2 | Operand size (R2 encoding) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Operand complete pulse |
| rd_data | output | 32 | Assembled operand |
| bus_addr | output | ADDR_W | Bus address |
| bus_func | output | 3 | Bus function code |
| bus_size | output | 2 | Remaining byte count |
| bus_read | output | 1 | Read/write line, 1 = read |
| cyc_early_n | output | 1 | Early cycle-start strobe |
| adr_stb_n | output | 1 | Address strobe |
| dat_stb_n | output | 1 | Data strobe |
| dbuf_oe_n | output | 1 | Data buffer enable |
| xfer_ack_n | input | 2 | Acknowledge and port width |
| bus_din | input | 32 | Data bus |

## Verification
The bench builds the block with ADDR_W = 12. This makes random addresses cover every low-offset alignment densely, and a directed long read at 0xFFE exercises the address wrap that follows a split. The slave model picks the port width at random for each cycle, inserts wait states and holds its acknowledge for a variable time. It fills unused lanes with junk, so any wrong lane choice or wrong byte placement corrupts the operand. Directed cases cover a long read from an 8-bit port, misaligned long and word reads, a three-byte read, and requests raised while busy.

// File: rtl/dynsz_pkg.sv
package dynsz_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_STROBE, ST_WAIT, ST_TERM, ST_REL
  } st_e;

  localparam logic [1:0] ACK_P32  = 2'b00;
  localparam logic [1:0] ACK_P16  = 2'b01;
  localparam logic [1:0] ACK_P8   = 2'b10;
  localparam logic [1:0] ACK_NONE = 2'b11;

  function automatic logic [2:0] size_to_count(input logic [1:0] s);
    return (s == 2'b00) ? 3'd4 : {1'b0, s};
  endfunction
endpackage

// File: rtl/dynsz_fsm.sv
module dynsz_fsm
  import dynsz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] ack_n,
  input  logic       rem_zero,
  output logic       load,
  output logic       capture,
  output logic       early_n,
  output logic       stb_n,
  output logic       buf_n,
  output logic       busy,
  output logic       done
);
  st_e  state, nxt;
  logic ack_idle;
  logic done_nxt;

  assign ack_idle = (ack_n == ACK_NONE);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (req_valid && ack_idle) nxt = ST_START;
      ST_START:  nxt = ST_STROBE;
      ST_STROBE: nxt = ST_WAIT;
      ST_WAIT:   if (!ack_idle) nxt = ST_TERM;
      ST_TERM:   nxt = ST_REL;
      ST_REL:    if (ack_idle) nxt = rem_zero ? ST_IDLE : ST_START;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign done_nxt = (state == ST_REL) && ack_idle && rem_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= done_nxt;
    end
  end

  assign load    = (state == ST_IDLE) && req_valid && ack_idle;
  assign capture = (state == ST_WAIT) && !ack_idle;
  assign early_n = (state != ST_START);
  assign stb_n   = !((state == ST_STROBE) || (state == ST_WAIT));
  assign buf_n   = !((state == ST_WAIT) || (state == ST_TERM));
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/dynsz_lane_pick.sv
module dynsz_lane_pick
  import dynsz_pkg::*;
(
  input  logic [1:0]        addr_lo,
  input  logic [1:0]        ack_n,
  input  logic [2:0]        rem,
  input  logic [DATA_W-1:0] op_cur,
  input  logic [DATA_W-1:0] din,
  output logic [2:0]        n_bytes,
  output logic [DATA_W-1:0] op_next
);
  logic [2:0] port_bytes;
  logic [1:0] offs;
  logic [2:0] avail;

  always_comb begin
    case (ack_n)
      ACK_P32: begin port_bytes = 3'd4; offs = addr_lo;              end
      ACK_P16: begin port_bytes = 3'd2; offs = {1'b0, addr_lo[0]};   end
      ACK_P8:  begin port_bytes = 3'd1; offs = 2'b00;                end
      default: begin port_bytes = 3'd0; offs = 2'b00;                end
    endcase
  end

  assign avail   = port_bytes - {1'b0, offs};
  assign n_bytes = (rem < avail) ? rem : avail;

  logic [7:0]       byte_val [LANES];
  logic [1:0]       pos_of   [LANES];
  logic [LANES-1:0] take;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    logic [1:0] lane;
    assign lane        = offs + 2'(k);
    assign byte_val[k] = din[{~lane, 3'b000} +: 8];
    assign pos_of[k]   = rem[1:0] - 2'd1 - 2'(k);
    assign take[k]     = (3'(k) < n_bytes);
  end

  always_comb begin
    op_next = op_cur;
    for (int k = 0; k < LANES; k++) begin
      if (take[k]) op_next[{pos_of[k], 3'b000} +: 8] = byte_val[k];
    end
  end
endmodule

// File: rtl/dynsz_xfer_regs.sv
module dynsz_xfer_regs
  import dynsz_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_fc,
  input  logic [1:0]        req_size,
  input  logic [2:0]        n_bytes,
  input  logic [DATA_W-1:0] op_next,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [2:0]        cur_fc,
  output logic [2:0]        rem,
  output logic [DATA_W-1:0] op
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_fc   <= '0;
      rem      <= '0;
      op       <= '0;
    end else if (load) begin
      cur_addr <= req_addr;
      cur_fc   <= req_fc;
      rem      <= size_to_count(req_size);
      op       <= '0;
    end else if (capture) begin
      cur_addr <= cur_addr + ADDR_W'(n_bytes);
      rem      <= rem - n_bytes;
      op       <= op_next;
    end
  end
endmodule

// File: rtl/dynsz_rd_ctrl.sv
module dynsz_rd_ctrl
  import dynsz_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_fc,
  input  logic [1:0]        req_size,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_func,
  output logic [1:0]        bus_size,
  output logic              bus_read,
  output logic              cyc_early_n,
  output logic              adr_stb_n,
  output logic              dat_stb_n,
  output logic              dbuf_oe_n,
  input  logic [1:0]        xfer_ack_n,
  input  logic [31:0]       bus_din
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              load, capture, stb_n;
  logic [2:0]        rem, n_bytes;
  logic [DATA_W-1:0] op, op_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dynsz_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .ack_n(xfer_ack_n),
    .rem_zero(rem == 3'd0), .load(load), .capture(capture),
    .early_n(cyc_early_n), .stb_n(stb_n), .buf_n(dbuf_oe_n),
    .busy(busy), .done(done)
  );

  dynsz_lane_pick u_lane (
    .addr_lo(bus_addr[1:0]), .ack_n(xfer_ack_n), .rem(rem),
    .op_cur(op), .din(bus_din), .n_bytes(n_bytes), .op_next(op_next)
  );

  dynsz_xfer_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .load(load), .capture(capture),
    .req_addr(req_addr), .req_fc(req_fc), .req_size(req_size),
    .n_bytes(n_bytes), .op_next(op_next), .cur_addr(bus_addr),
    .cur_fc(bus_func), .rem(rem), .op(op)
  );

  assign adr_stb_n = stb_n;
  assign dat_stb_n = stb_n;
  assign bus_read  = 1'b1;
  assign bus_size  = rem[1:0];
  assign rd_data   = op;
endmodule

// File: rtl/dynsz_rd_ctrl_chk.sv
module dynsz_rd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       done,
  input logic [1:0] bus_size,
  input logic       cyc_early_n,
  input logic       adr_stb_n,
  input logic       dbuf_oe_n,
  input logic [1:0] xfer_ack_n
);
  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && xfer_ack_n == 2'b11) |=> busy);
  a_r2_size_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!adr_stb_n && $past(!adr_stb_n)) |-> $stable(bus_size));
  a_r3_early_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_early_n |=> cyc_early_n);
  a_r3_early_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adr_stb_n) |-> $past(!cyc_early_n));
  a_r4_buf_on_after: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbuf_oe_n) |-> ($past(!adr_stb_n) && !adr_stb_n));
  a_r4_buf_off_after: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbuf_oe_n) |-> ($past(adr_stb_n) && adr_stb_n));
  a_r5_hold_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!adr_stb_n && xfer_ack_n == 2'b11) |=> !adr_stb_n);
  a_r5_release_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!adr_stb_n && !dbuf_oe_n && xfer_ack_n != 2'b11) |=> adr_stb_n);
  a_r10_no_start_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack_n != 2'b11) |=> (cyc_early_n && !done));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind dynsz_rd_ctrl dynsz_rd_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .bus_size(bus_size), .cyc_early_n(cyc_early_n), .adr_stb_n(adr_stb_n),
  .dbuf_oe_n(dbuf_oe_n), .xfer_ack_n(xfer_ack_n)
);

// File: tb/test_dynsz_rd_ctrl.sv
`timescale 1ns/1ps
module test_dynsz_rd_ctrl;
  localparam int unsigned AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [2:0]    req_fc;
  logic [1:0]    req_size;
  logic          busy, done, bus_read, cyc_early_n, adr_stb_n, dat_stb_n, dbuf_oe_n;
  logic [31:0]   rd_data;
  logic [AW-1:0] bus_addr;
  logic [2:0]    bus_func;
  logic [1:0]    bus_size;
  logic [1:0]    xfer_ack_n;
  logic [31:0]   bus_din;

  always #10 clk = ~clk;

  dynsz_rd_ctrl #(.ADDR_W(AW)) i_dynsz_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_fc(req_fc), .req_size(req_size), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_func(bus_func),
    .bus_size(bus_size), .bus_read(bus_read), .cyc_early_n(cyc_early_n),
    .adr_stb_n(adr_stb_n), .dat_stb_n(dat_stb_n), .dbuf_oe_n(dbuf_oe_n),
    .xfer_ack_n(xfer_ack_n), .bus_din(bus_din)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int force_port = -1;
  logic [AW-1:0] m_addr;
  logic [2:0]    m_rem;
  logic [2:0]    m_fc;
  int            m_cycles;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return (a[7:0] * 8'd37) ^ {a[11:8], a[3:0]} ^ 8'h5A;
  endfunction

  function automatic logic [31:0] exp_operand(input logic [AW-1:0] a, input int s);
    logic [31:0] r = '0;
    for (int i = 0; i < s; i++) r = {r[23:0], mem_byte(a + AW'(i))};
    return r;
  endfunction

  // slave model: acknowledges with a per-cycle port width
  initial begin
    xfer_ack_n = 2'b11;
    bus_din    = '0;
    forever begin
      @(negedge clk);
      if (rst_n && !adr_stb_n && !dbuf_oe_n && xfer_ack_n == 2'b11) begin
        int pc, pw, off, nb, ws, hold;
        logic [31:0] dv;
        chk(bus_size == m_rem[1:0], "R2 size lines", {30'd0, bus_size}, {30'd0, m_rem[1:0]});
        chk(bus_func == m_fc, "R2 function code", {29'd0, bus_func}, {29'd0, m_fc});
        chk(bus_addr == m_addr, "R9 cycle address", {20'd0, bus_addr}, {20'd0, m_addr});
        chk(bus_read && !dat_stb_n, "R3 read level and data strobe", {31'd0, bus_read}, 32'd1);
        ws = $urandom_range(0, 2);
        repeat (ws) begin
          @(negedge clk);
          chk(!adr_stb_n && !dbuf_oe_n, "R5 strobes held during wait", {31'd0, adr_stb_n}, 32'd0);
        end
        pc = (force_port >= 0) ? force_port : $urandom_range(0, 2);
        dv = $urandom();
        if (pc == 0) begin
          pw = 4; off = int'(m_addr[1:0]);
          for (int j = 0; j < 4; j++) dv[(3-j)*8 +: 8] = mem_byte({m_addr[AW-1:2], 2'(j)});
        end else if (pc == 1) begin
          pw = 2; off = int'(m_addr[0]);
          for (int j = 0; j < 2; j++) dv[(3-j)*8 +: 8] = mem_byte({m_addr[AW-1:1], 1'(j)});
        end else begin
          pw = 1; off = 0;
          dv[31:24] = mem_byte(m_addr);
        end
        xfer_ack_n = 2'(pc);
        bus_din    = dv;
        nb = (int'(m_rem) < pw - off) ? int'(m_rem) : pw - off;
        m_addr = m_addr + AW'(nb);
        m_rem  = m_rem - 3'(nb);
        m_cycles++;
        @(negedge clk);
        chk(adr_stb_n && dat_stb_n && !dbuf_oe_n, "R5 strobes off one clock after ack",
            {30'd0, adr_stb_n, dbuf_oe_n}, 32'd2);
        hold = $urandom_range(0, 3);
        repeat (hold) begin
          @(negedge clk);
          chk(adr_stb_n && cyc_early_n && !done, "R10 held off while ack asserted",
              {29'd0, adr_stb_n, cyc_early_n, done}, 32'd6);
        end
        xfer_ack_n = 2'b11;
        bus_din    = $urandom();
      end
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] sz, input logic [2:0] fc,
                         input bit poke, input int exp_cyc);
    int s, t, guard;
    logic [31:0] ev;
    guard = 0;
    while ((busy || xfer_ack_n != 2'b11) && guard < 100) begin @(negedge clk); guard++; end
    s  = (sz == 2'b00) ? 4 : int'(sz);
    ev = exp_operand(a, s);
    m_addr = a; m_rem = 3'(s); m_fc = fc; m_cycles = 0;
    req_valid = 1'b1; req_addr = a; req_fc = fc; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R1 busy after accept", {31'd0, busy}, 32'd1);
    t = 0;
    while (!done && t < 400) begin
      if (poke && t == 2) begin
        req_valid = 1'b1; req_addr = ~a; req_size = 2'b00; req_fc = ~fc;
      end else req_valid = 1'b0;
      @(negedge clk);
      t++;
    end
    req_valid = 1'b0;
    chk(done, "R11 done raised", {31'd0, done}, 32'd1);
    chk(rd_data == ev, "R8 assembled operand (R7 lanes)", rd_data, ev);
    chk(m_rem == 3'd0, "R9 all bytes moved before done", {29'd0, m_rem}, 32'd0);
    chk(!busy, "R11 busy low at done", {31'd0, busy}, 32'd0);
    if (exp_cyc > 0) chk(m_cycles == exp_cyc, "R6 bus cycle count", 32'(m_cycles), 32'(exp_cyc));
    @(negedge clk);
    chk(!done, "R11 single clock pulse", {31'd0, done}, 32'd0);
    chk(!busy, "R1 request while busy ignored", {31'd0, busy}, 32'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_fc = '0; req_size = '0;
    repeat (3) @(negedge clk);
    chk(adr_stb_n && dat_stb_n && cyc_early_n && dbuf_oe_n && !busy && !done,
        "R12 reset state", {26'd0, adr_stb_n, dat_stb_n, cyc_early_n, dbuf_oe_n, busy, done}, 32'h3C);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    force_port = 2; do_read(12'h100, 2'b00, 3'd5, 1'b0, 4); // R6 long from 8-bit port
    force_port = 0; do_read(12'h103, 2'b00, 3'd1, 1'b0, 2); // R6 misaligned long, 32-bit
    force_port = 1; do_read(12'h201, 2'b10, 3'd2, 1'b0, 2); // R6 odd word, 16-bit
    force_port = 0; do_read(12'h301, 2'b11, 3'd6, 1'b0, 1); // R6 three bytes fit
    force_port = 0; do_read(12'hFFE, 2'b00, 3'd3, 1'b0, 2); // R9 wrap
    force_port = 2; do_read(12'h0A7, 2'b01, 3'd7, 1'b1, 1); // R1 poke while busy
    force_port = 1; do_read(12'h402, 2'b00, 3'd0, 1'b1, 2); // R7 upper half lanes
    force_port = -1;
    for (int i = 0; i < 300; i++) begin
      do_read(AW'($urandom()), 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
              ($urandom_range(0, 9) == 0), 0);
    end
    finish_run();
  end
endmodule